// File: doc/BRIEF.md
# Repeatable String Store Sequencer

This block runs a single "store accumulator to memory" string operation. A `go` pulse loads the destination index, the count, the accumulator value and three control flags: repeat, element width and direction. The block then issues memory writes on a valid/ready write port. After each accepted write it moves the index by one element in the selected direction. When the operation is repeated, it also decrements the count.

In repeated mode the block samples a pending-interrupt input only after a store has been accepted, never before one. If the input is high at that point, the block leaves the loop with a `take_irq` pulse. The index and count are left at their updated values, so re-issuing the operation from `idx_out`/`cnt_out` resumes with the elements that remain. Because of this ordering, every entry with a non-zero count completes at least one store, even when an interrupt is pending on every cycle.

The write port follows valid/ready rules. `wr_valid` stays high, with `wr_addr`, `wr_data` and `wr_wide` stable, until a cycle in which `wr_ready` is high. The store is transferred in that cycle. The consumer may hold `wr_ready` low for any number of cycles; the block adds no timeout.

Top module: `strstore_seq`

## Requirements
- R1: After reset `wr_valid`, `done` and `take_irq` are low and `idx_out`, `cnt_out` are zero.
- R2: A `go` while no store is outstanding latches `idx_in`, `cnt_in`, `acc_in`, `rep_en`, `wide` and `dir_down`. With `rep_en`=1 and `cnt_in`=0, no write is issued and `done` pulses in the next cycle.
- R3: Each store raises `wr_valid` with `wr_addr` equal to the current index and `wr_wide` equal to the width flag. `wr_data` is the accumulator when wide, and otherwise its low 8 bits with the upper bits zero. All of these stay stable until the cycle in which `wr_ready` is high.
- R4: The index changes only at an accepted store and becomes visible in the next cycle. It moves by +1 (byte) or +2 (word) when `dir_down`=0, and by -1 or -2 when `dir_down`=1, wrapping modulo 2^AW.
- R5: In repeated mode the count drops by one at each accepted store. Without repeat it never changes.
- R6: Without repeat, exactly one store is made and `done` pulses in the cycle after it is accepted; `irq_pend` is ignored.
- R7: In repeated mode, if `irq_pend` is high in the cycle a store is accepted, `take_irq` pulses in the next cycle and the block stops with the updated index and count. This holds even when the count has just reached zero.
- R8: In repeated mode with `irq_pend` low at acceptance, the block issues the next store when the decremented count is non-zero. Otherwise `done` pulses in the next cycle.
- R9: With `irq_pend` held high permanently, every entry whose count is non-zero completes exactly one store before `take_irq`.
- R10: `done` and `take_irq` are one-cycle pulses and never high together. A `go` while `wr_valid` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken when no store is outstanding |
| rep_en | input | 1 | Repeat prefix present |
| wide | input | 1 | 1 = word elements, 0 = byte elements |
| dir_down | input | 1 | 1 = index decreases, 0 = increases |
| acc_in | input | DW | Accumulator value to store |
| idx_in | input | AW | Starting destination index |
| cnt_in | input | CW | Starting count |
| irq_pend | input | 1 | Interrupt pending |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_wide | output | 1 | Write is a word |
| idx_out | output | AW | Current destination index |
| cnt_out | output | CW | Current count |
| done | output | 1 | Operation finished pulse |
| take_irq | output | 1 | Exit-for-interrupt pulse |

## Verification
The bench targets the repeated store with a count of zero. A design that stored before testing the count would emit a stray write there. It also targets an interrupt that is pending permanently: a block that checked before storing would emit `take_irq` forever with no write and no progress. The bench exercises long back-pressure, where updating the index early or dropping a stalled request shows up as a moved address or a lost store. It also covers an interrupt that lands on the store which brings the count to zero; a block that tested the count first would emit `done` instead of `take_irq`. Index wrap in both directions and a `go` asserted during a stall are compared cycle by cycle against the behavioural model.

// File: rtl/strstore_pkg.sv
package strstore_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_STORE = 1'b1
  } seq_state_e;

  function automatic logic [1:0] elem_bytes(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/strstore_idx_step.sv
module strstore_idx_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx_i,
  input  logic          wide_i,
  input  logic          down_i,
  output logic [AW-1:0] idx_o
);
  import strstore_pkg::*;
  localparam int PADW = AW - 2;

  logic [AW-1:0] step;
  assign step = {{PADW{1'b0}}, elem_bytes(wide_i)};

  always_comb begin
    if (down_i) idx_o = idx_i - step;
    else        idx_o = idx_i + step;
  end
endmodule

// File: rtl/strstore_cnt_dec.sv
module strstore_cnt_dec #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  assign cnt_o  = cnt_i - ONE;
  assign last_o = (cnt_i == ONE);
endmodule

// File: rtl/strstore_ctrl.sv
module strstore_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic rep_in_i,
  input  logic cnt_in_zero_i,
  input  logic rep_q_i,
  input  logic ready_i,
  input  logic irq_i,
  input  logic last_i,
  output logic load_o,
  output logic adv_o,
  output logic busy_o,
  output logic done_o,
  output logic tirq_o
);
  import strstore_pkg::*;

  seq_state_e state_q, state_d;
  logic done_d, tirq_d;

  assign busy_o = (state_q == SEQ_STORE);
  assign load_o = !busy_o && go_i;
  assign adv_o  = busy_o && ready_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    tirq_d  = 1'b0;
    if (load_o) begin
      if (rep_in_i && cnt_in_zero_i) done_d  = 1'b1;
      else                           state_d = SEQ_STORE;
    end else if (adv_o) begin
      if (!rep_q_i) begin
        done_d  = 1'b1;
        state_d = SEQ_IDLE;
      end else if (irq_i) begin
        tirq_d  = 1'b1;
        state_d = SEQ_IDLE;
      end else if (last_i) begin
        done_d  = 1'b1;
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_o  <= 1'b0;
      tirq_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      tirq_o  <= tirq_d;
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && tirq_o));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || tirq_o) |=> !(done_o || tirq_o) || $past(load_o));
  p_irq_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tirq_o |-> $past(adv_o) && $past(rep_q_i));
  p_norep_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o && !rep_q_i) |=> done_o && !busy_o);
endmodule

// File: rtl/strstore_seq.sv
module strstore_seq #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rep_en,
  input  logic          wide,
  input  logic          dir_down,
  input  logic [DW-1:0] acc_in,
  input  logic [AW-1:0] idx_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          irq_pend,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_wide,
  output logic [AW-1:0] idx_out,
  output logic [CW-1:0] cnt_out,
  output logic          done,
  output logic          take_irq
);
  localparam int BYTEW = 8;
  localparam int HIW   = DW - BYTEW;

  logic [AW-1:0] idx_q, idx_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [DW-1:0] acc_q;
  logic          rep_q, wide_q, down_q;
  logic          last, load, adv, busy;

  strstore_idx_step #(.AW(AW)) u_step (
    .idx_i (idx_q),
    .wide_i(wide_q),
    .down_i(down_q),
    .idx_o (idx_nx)
  );

  strstore_cnt_dec #(.CW(CW)) u_cnt (
    .cnt_i (cnt_q),
    .cnt_o (cnt_nx),
    .last_o(last)
  );

  strstore_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .rep_in_i     (rep_en),
    .cnt_in_zero_i(cnt_in == '0),
    .rep_q_i      (rep_q),
    .ready_i      (wr_ready),
    .irq_i        (irq_pend),
    .last_i       (last),
    .load_o       (load),
    .adv_o        (adv),
    .busy_o       (busy),
    .done_o       (done),
    .tirq_o       (take_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      rep_q  <= 1'b0;
      wide_q <= 1'b0;
      down_q <= 1'b0;
    end else if (load) begin
      idx_q  <= idx_in;
      cnt_q  <= cnt_in;
      acc_q  <= acc_in;
      rep_q  <= rep_en;
      wide_q <= wide;
      down_q <= dir_down;
    end else if (adv) begin
      idx_q <= idx_nx;
      if (rep_q) cnt_q <= cnt_nx;
    end
  end

  generate
    if (HIW > 0) begin : g_lane
      assign wr_data = wide_q ? acc_q : {{HIW{1'b0}}, acc_q[BYTEW-1:0]};
    end else begin : g_flat
      assign wr_data = acc_q;
    end
  endgenerate

  assign wr_valid = busy;
  assign wr_addr  = idx_q;
  assign wr_wide  = wide_q;
  assign idx_out  = idx_q;
  assign cnt_out  = cnt_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr)
      && $stable(wr_data) && $stable(wr_wide));
  p_idx_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(idx_out) && $stable(cnt_out));
  p_cnt_norep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !rep_q) |=> $stable(cnt_out));
  p_cnt_rep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rep_q) |=> cnt_out == $past(cnt_out) - CW'(1));
  p_zero_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && go && rep_en && cnt_in == '0) |=> !wr_valid && done);
endmodule

// File: tb/tb_strstore_seq.sv
module tb_strstore_seq;
  localparam int AW = 16, CW = 16, DW = 16;

  logic clk = 0, rst_n = 0;
  logic go = 0, rep_en = 0, wide = 0, dir_down = 0, irq_pend = 0, wr_ready = 0;
  logic [DW-1:0] acc_in = '0;
  logic [AW-1:0] idx_in = '0;
  logic [CW-1:0] cnt_in = '0;
  logic wr_valid, wr_wide, done, take_irq;
  logic [AW-1:0] wr_addr, idx_out;
  logic [CW-1:0] cnt_out;
  logic [DW-1:0] wr_data;

  strstore_seq #(.AW(AW), .CW(CW), .DW(DW)) dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0, stores = 0;
  int rdy_mode = 0, irq_mode = 0;

  // behavioural reference
  logic m_busy = 0, m_rep = 0, m_wide = 0, m_dn = 0, m_done = 0, m_tirq = 0;
  logic [AW-1:0] m_idx = '0;
  logic [CW-1:0] m_cnt = '0;
  logic [DW-1:0] m_acc = '0;

  always @(posedge clk) begin
    cyc++;
    if (wr_valid && wr_ready) stores++;
    m_done = 0; m_tirq = 0;
    if (!rst_n) begin
      m_busy = 0; m_idx = '0; m_cnt = '0; m_acc = '0; m_rep = 0; m_wide = 0; m_dn = 0;
    end else if (!m_busy) begin
      if (go) begin
        m_idx = idx_in; m_cnt = cnt_in; m_acc = acc_in;
        m_rep = rep_en; m_wide = wide; m_dn = dir_down;
        if (rep_en && cnt_in == 0) m_done = 1;
        else m_busy = 1;
      end
    end else if (wr_ready) begin
      if (m_dn) m_idx = m_idx - (m_wide ? 2 : 1);
      else      m_idx = m_idx + (m_wide ? 2 : 1);
      if (!m_rep) begin m_done = 1; m_busy = 0; end
      else begin
        m_cnt = m_cnt - 1;
        if (irq_pend) begin m_tirq = 1; m_busy = 0; end
        else if (m_cnt == 0) begin m_done = 1; m_busy = 0; end
      end
    end
  end

  task automatic chk(string req, string nm, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "wr_valid", wr_valid, m_busy);
      if (m_busy) begin
        chk("R3", "wr_addr", wr_addr, m_idx);
        chk("R3", "wr_data", wr_data, m_wide ? m_acc : {8'h00, m_acc[7:0]});
        chk("R3", "wr_wide", wr_wide, m_wide);
      end
      chk("R4", "idx_out", idx_out, m_idx);
      chk("R5", "cnt_out", cnt_out, m_cnt);
      chk("R8", "done", done, m_done);
      chk("R7", "take_irq", take_irq, m_tirq);
      chk("R10", "exclusive", done & take_irq, 0);
    end
    case (rdy_mode)
      0: wr_ready <= 1;
      1: wr_ready <= cyc[0];
      default: wr_ready <= (cyc % 5 == 0);
    endcase
    case (irq_mode)
      0: irq_pend <= 0;
      1: irq_pend <= 1;
      default: irq_pend <= (cyc % 3 == 0);
    endcase
  end

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // one entry: returns stores made and which pulse ended it
  task automatic run(input logic r, input logic w, input logic d, input logic [AW-1:0] ix,
                     input logic [CW-1:0] ct, input logic [DW-1:0] a,
                     output int n, output logic got_irq);
    @(negedge clk);
    rep_en = r; wide = w; dir_down = d; idx_in = ix; cnt_in = ct; acc_in = a; go = 1;
    stores = 0;
    @(negedge clk); go = 0;
    for (int k = 0; k < 2000 && !(done || take_irq); k++) @(negedge clk);
    n = stores; got_irq = take_irq;
  endtask

  int n; logic gi;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset wr_valid", wr_valid, 0);
    chk("R1", "reset done", done | take_irq, 0);
    chk("R1", "reset idx/cnt", {idx_out, cnt_out}, 0);
    rst_n = 1;

    run(1, 1, 0, 16'h0100, 0, 16'hBEEF, n, gi);
    chk("R2", "stores with rep count 0", n, 0);

    rdy_mode = 1;
    run(0, 0, 0, 16'h0200, 5, 16'h12A5, n, gi);
    chk("R6", "single store", n, 1);
    chk("R6", "count unchanged", cnt_out, 5);
    chk("R4", "byte up index", idx_out, 16'h0201);

    irq_mode = 1;
    run(0, 1, 1, 16'h0000, 3, 16'h5A5A, n, gi);
    chk("R6", "irq ignored without repeat", gi, 0);
    chk("R4", "word down wrap", idx_out, 16'hFFFE);
    irq_mode = 0;

    rdy_mode = 2;
    run(1, 1, 0, 16'hFFFC, 4, 16'h0F0F, n, gi);
    chk("R8", "four stores", n, 4);
    chk("R4", "word up wrap", idx_out, 16'h0004);
    chk("R5", "count exhausted", cnt_out, 0);

    run(1, 0, 1, 16'h0010, 6, 16'h00C3, n, gi);
    chk("R8", "six byte stores", n, 6);
    chk("R4", "byte down", idx_out, 16'h000A);

    // R9: storm, resume until done
    irq_mode = 1; rdy_mode = 1;
    begin
      logic [AW-1:0] ix = 16'h0400; logic [CW-1:0] ct = 5;
      for (int e = 0; e < 5; e++) begin
        run(1, 1, 0, ix, ct, 16'h3333, n, gi);
        chk("R9", "one store per entry", n, 1);
        chk("R7", "exit via take_irq", gi, 1);
        chk("R7", "count resumed", cnt_out, ct - 1);
        ix = idx_out; ct = cnt_out;
      end
      chk("R7", "final index", idx_out, 16'h040A);
      run(1, 1, 0, ix, ct, 16'h3333, n, gi);
      chk("R2", "resume at zero ends", n, 0);
    end

    // irq at random points
    irq_mode = 2; rdy_mode = 0;
    run(1, 0, 0, 16'h0800, 9, 16'h0044, n, gi);
    chk("R7", "stores before irq nonzero", n > 0, 1);

    // R10: go during stall ignored
    irq_mode = 0; rdy_mode = 3;
    @(negedge clk);
    rep_en = 0; wide = 0; dir_down = 0; idx_in = 16'h0900; cnt_in = 1; acc_in = 16'h0077; go = 1;
    @(negedge clk); idx_in = 16'h0A00; acc_in = 16'h0099;
    @(negedge clk); go = 0;
    chk("R10", "go during store ignored", wr_addr, 16'h0900);
    for (int k = 0; k < 50 && !done; k++) @(negedge clk);
    chk("R10", "finished", idx_out, 16'h0901);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule